// File: doc/BRIEF.md
# Boost Switch PWM Gate Latch

This block turns a per-period start strobe and two comparator results into the on/off command for the boost power switch. Each switching period starts with a forced off interval of fixed length. During that interval the block holds the external ramp discharged through a release output. When the interval ends the ramp is let go, and the gate turns on as soon as the ramp-versus-averaged-current comparator reports a crossing. It stays on until the next period starts.

A second comparator flags an excessive switch current. Its output is filtered by a run-length deglitcher. A confirmed event sets a current-limit latch, and that latch forces the gate off for the rest of the period. The forced off interval has absolute priority: it clears both the gate-on latch and the current-limit latch and masks every other input. An external enable gates the final command without disturbing either latch.

All durations are parameters in system-clock cycles. At 125 MHz the defaults give a 600 ns forced off time (75 cycles) and a 200 ns deglitch (25 cycles). With a 65 kHz period of 1923 cycles, the longest on time is therefore 1847 cycles, which is a duty cycle of about 96 %.

Top module: `boost_pwm_gate`

## Requirements
- R1: While `rstN` is low, `gateOut` and `curLimit` are 0 and `rampRelease` is 0. After reset is released, `rampRelease` stays 0 for exactly MIN_OFF_CYC further cycles, as if a period had just started.
- R2: A `cycleStart` sampled high at a clock edge drives `rampRelease` and `gateOut` low from that edge for exactly MIN_OFF_CYC cycles. A new `cycleStart` inside that interval restarts the full count.
- R3: `rampRelease` is 1 exactly when no forced off interval is running. It never rises on the edge right after a sampled `cycleStart`.
- R4: A `rampCross` sampled high while no forced off interval is running sets the gate-on latch. `gateOut` goes to 1 in the next cycle (given `enable` is 1 and `curLimit` is 0) and stays 1 until the next forced off interval.
- R5: A `rampCross` sampled during the forced off interval has no effect. The gate stays off after the interval ends until a later crossing arrives.
- R6: `peakRaw` sampled high on GLITCH_CYC consecutive edges sets `curLimit` one edge later, and `gateOut` drops in that same cycle. A high run shorter than GLITCH_CYC changes neither output.
- R7: Once set, `curLimit` and the forced-off gate are held until the next forced off interval clears them. A confirmed peak event during the forced off interval does not set `curLimit`.
- R8: `enable` low forces `gateOut` to 0 in the same cycle without changing either latch. When `enable` returns to 1, the gate resumes in the same cycle if it was latched on.
- R9: A period that sees no crossing keeps `gateOut` at 0 for all of its cycles, which gives 0 % duty.
- R10: With `rampCross` held high and a period of P cycles, `gateOut` is high for P − MIN_OFF_CYC − 1 cycles per period. At 65 kHz with default parameters this is at least 95 % duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleStart | input | 1 | One-cycle strobe that begins a switching period |
| rampCross | input | 1 | Ramp has crossed the averaged-current level |
| peakRaw | input | 1 | Unfiltered peak-current comparator output |
| enable | input | 1 | Gate enable; 0 forces the gate off |
| gateOut | output | 1 | Switch on command, active high |
| rampRelease | output | 1 | 1 lets the ramp rise; 0 holds it discharged |
| curLimit | output | 1 | Current-limit latch state for this period |

## Verification
The bench targets the exact length of the forced off interval, both after reset and after a restart that lands inside a running interval. An off-by-one counter would show up here as a duty cycle one cycle too long or too short, or as a restart that does not extend the interval. It drives peak pulses exactly one cycle shorter than the filter and exactly as long as it. A wrong comparison would either let a glitch trip the switch or make a real event arrive late. It also raises crossings and confirmed peaks during the forced interval, where a design with the wrong priority would keep the gate latched on or carry a stale limit into the new period. Finally, it toggles the enable while the gate is latched on, to catch a design that clears the latch instead of only masking the output.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  // Strobes the control half hands to the latch datapath each cycle.
  typedef struct packed {
    logic minOff;    // forced off interval running (highest priority)
    logic peakTrip;  // peak event confirmed by the deglitcher
  } bpg_strobe_t;

endpackage

// File: rtl/bpg_ctrl.sv
module bpg_ctrl
  import bpg_pkg::*;
#(
  parameter int MIN_OFF_CYC = 75,
  parameter int GLITCH_CYC  = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycleStart,
  input  logic        peakRaw,
  output bpg_strobe_t strobes,
  output logic        rampRelease
);

  localparam int OFF_W = (MIN_OFF_CYC < 1) ? 1 : $clog2(MIN_OFF_CYC + 1);
  localparam int GL_W  = (GLITCH_CYC < 1) ? 1 : $clog2(GLITCH_CYC + 1);
  localparam logic [OFF_W-1:0] OFF_LOAD = OFF_W'(MIN_OFF_CYC);
  localparam logic [GL_W-1:0]  GL_FULL  = GL_W'(GLITCH_CYC);

  logic [OFF_W-1:0] offCnt;
  logic [GL_W-1:0]  runCnt;
  logic             minOffActive;

  // Forced off interval: loaded by reset or a period start, counts to zero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt <= OFF_LOAD;
    end else if (cycleStart) begin
      offCnt <= OFF_LOAD;
    end else if (offCnt != '0) begin
      offCnt <= offCnt - OFF_W'(1);
    end
  end

  // Deglitcher: length of the current high run of the raw comparator, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (!peakRaw) begin
      runCnt <= '0;
    end else if (runCnt != GL_FULL) begin
      runCnt <= runCnt + GL_W'(1);
    end
  end

  assign minOffActive     = (offCnt != '0);
  assign strobes.minOff   = minOffActive;
  assign strobes.peakTrip = (runCnt == GL_FULL);
  assign rampRelease      = !minOffActive;

  AST_RELEASE_NOT_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rampRelease) |-> !$past(cycleStart)) else $error("release after start"); // R3
  AST_START_HOLDS_RAMP: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> !rampRelease) else $error("ramp not held after start"); // R2

endmodule

// File: rtl/bpg_latch.sv
module bpg_latch
  import bpg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  bpg_strobe_t strobes,
  input  logic        rampCross,
  input  logic        enable,
  output logic        gateOut,
  output logic        curLimit
);

  logic pwmOn;
  logic clLatch;

  // Gate-on latch: the forced off interval wins over a crossing.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmOn <= 1'b0;
    end else if (strobes.minOff) begin
      pwmOn <= 1'b0;
    end else if (rampCross) begin
      pwmOn <= 1'b1;
    end
  end

  // Current-limit latch: same priority, held for the rest of the period.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clLatch <= 1'b0;
    end else if (strobes.minOff) begin
      clLatch <= 1'b0;
    end else if (strobes.peakTrip) begin
      clLatch <= 1'b1;
    end
  end

  assign gateOut  = pwmOn & ~clLatch & ~strobes.minOff & enable;
  assign curLimit = clLatch;

  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    clLatch && !strobes.minOff |=> clLatch) else $error("limit dropped mid period"); // R7
  AST_ON_CLEARED_BY_MINOFF: assert property (@(posedge clk) disable iff (!rstN)
    strobes.minOff |=> !pwmOn) else $error("on latch survived forced off"); // R2

endmodule

// File: rtl/boost_pwm_gate.sv
module boost_pwm_gate
  import bpg_pkg::*;
#(
  parameter int MIN_OFF_CYC = 75,
  parameter int GLITCH_CYC  = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycleStart,
  input  logic rampCross,
  input  logic peakRaw,
  input  logic enable,
  output logic gateOut,
  output logic rampRelease,
  output logic curLimit
);

  bpg_strobe_t strobes;

  bpg_ctrl #(
    .MIN_OFF_CYC(MIN_OFF_CYC),
    .GLITCH_CYC (GLITCH_CYC)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cycleStart (cycleStart),
    .peakRaw    (peakRaw),
    .strobes    (strobes),
    .rampRelease(rampRelease)
  );

  bpg_latch i_latch (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rampCross(rampCross),
    .enable   (enable),
    .gateOut  (gateOut),
    .curLimit (curLimit)
  );

  AST_LIMIT_NEEDS_PEAK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(curLimit) |-> $past(peakRaw, 2)) else $error("limit without peak"); // R6
  AST_GATE_NEEDS_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) && $past(enable) |-> $past(rampCross)) else $error("gate rose without crossing"); // R4

endmodule

// File: tb/test_boost_pwm_gate.sv
module test_boost_pwm_gate;

  localparam int M = 75;
  localparam int G = 25;
  localparam int P = 1923;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleStart = 1'b0;
  logic rampCross = 1'b0;
  logic peakRaw = 1'b0;
  logic enable = 1'b1;
  logic gateOut, rampRelease, curLimit;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string ph = "R1";

  // behavioural reference state
  int offLeft = M;
  int run = 0;
  bit on = 0;
  bit lim = 0;
  bit wasOff, tripNow;

  always #4 clk = ~clk;

  boost_pwm_gate #(.MIN_OFF_CYC(M), .GLITCH_CYC(G)) i_boost_pwm_gate (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .rampCross(rampCross),
    .peakRaw(peakRaw), .enable(enable), .gateOut(gateOut),
    .rampRelease(rampRelease), .curLimit(curLimit)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      offLeft = M; run = 0; on = 0; lim = 0;
    end else begin
      wasOff  = (offLeft != 0);
      tripNow = (run == G);
      if (cycleStart) offLeft = M;
      else if (offLeft > 0) offLeft = offLeft - 1;
      if (wasOff) begin
        on = 0; lim = 0;
      end else begin
        if (rampCross) on = 1;
        if (tripNow) lim = 1;
      end
      if (peakRaw) run = (run < G) ? run + 1 : G;
      else run = 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    chk(ph, "gateOut", int'(gateOut), int'(on && !lim && offLeft == 0 && enable));
    chk(ph, "rampRelease", int'(rampRelease), int'(offLeft == 0));
    chk(ph, "curLimit", int'(curLimit), int'(lim));
  endtask

  task automatic step(bit cs, bit cr, bit pk, bit en);
    compareModel();
    cycleStart = cs; rampCross = cr; peakRaw = pk; enable = en;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1);
  endtask

  task automatic startAndCross();
    step(1, 0, 0, 1);
    idle(M + 2);
    step(0, 1, 0, 1);
    idle(1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1: reset state
    ph = "R1";
    idle(4);
    rstN = 1'b1;
    cnt = 0;
    for (int j = 0; j < M + 5; j++) begin
      if (!rampRelease) cnt++;
      step(0, 0, 0, 1);
    end
    chk("R1", "release-low cycles after reset", cnt, M);

    // R4: crossing after release turns gate on and holds it
    ph = "R4";
    startAndCross();
    idle(5);
    chk("R4", "gate held on", int'(gateOut), 1);

    // R5: crossings during forced off are ignored
    ph = "R5";
    step(1, 0, 0, 1);
    for (int j = 0; j < M; j++) step(0, 1, 0, 1);
    idle(4);
    chk("R5", "gate after masked crossings", int'(gateOut), 0);

    // R6: deglitch length
    ph = "R6";
    startAndCross();
    for (int j = 0; j < G - 1; j++) step(0, 0, 1, 1);
    idle(4);
    chk("R6", "short pulse curLimit", int'(curLimit), 0);
    chk("R6", "short pulse gate", int'(gateOut), 1);
    for (int j = 0; j < G; j++) step(0, 0, 1, 1);
    idle(1);
    chk("R6", "trip curLimit", int'(curLimit), 1);
    chk("R6", "trip gate", int'(gateOut), 0);

    // R7: held until next period; trip inside forced off is discarded
    ph = "R7";
    for (int j = 0; j < 6; j++) step(0, 1, 0, 1);
    chk("R7", "limit held", int'(curLimit), 1);
    chk("R7", "gate held off", int'(gateOut), 0);
    step(1, 0, 1, 1);
    for (int j = 1; j < M - 1; j++) step(0, 0, 1, 1);
    idle(5);
    chk("R7", "limit cleared by forced off", int'(curLimit), 0);
    step(0, 1, 0, 1);
    idle(1);
    chk("R7", "gate on in new period", int'(gateOut), 1);

    // R8: enable masks only the output
    ph = "R8";
    for (int j = 0; j < 3; j++) begin
      step(0, 0, 0, 0);
      chk("R8", "gate with enable low", int'(gateOut), 0);
    end
    step(0, 0, 0, 1);
    chk("R8", "gate after enable returns", int'(gateOut), 1);

    // R9: no crossing, whole period off
    ph = "R9";
    cnt = 0;
    step(1, 0, 0, 1);
    for (int j = 0; j < 300; j++) begin
      if (gateOut) cnt++;
      step(0, 0, 0, 1);
    end
    chk("R9", "gate-high cycles without crossing", cnt, 0);

    // R2: restart inside forced off interval
    ph = "R2";
    idle(2);
    cnt = 0;
    step(1, 0, 0, 1);
    for (int j = 1; j < 2 * M + 10; j++) begin
      if (!rampRelease) cnt++;
      step((j == M / 2) ? 1'b1 : 1'b0, 0, 0, 1);
    end
    chk("R2", "release-low cycles with restart", cnt, M / 2 + M);

    // R10: maximum duty with crossing held high
    ph = "R10";
    for (int j = 0; j < P; j++) step(j == 0, 1, 0, 1);
    cnt = 0;
    for (int j = 0; j < P; j++) begin
      if (gateOut) cnt++;
      step(j == 0, 1, 0, 1);
    end
    chk("R10", "gate-high cycles per period", cnt, P - M - 1);
    chk("R10", "duty at least 95 percent", int'(cnt * 100 >= 95 * P), 1);

    // R3 and mixed traffic against the reference
    ph = "R3";
    for (int j = 0; j < 4000; j++) begin
      bit cs = ($urandom_range(0, 249) == 0);
      bit cr = ($urandom_range(0, 29) == 0);
      bit pk = ($urandom_range(0, 9) < 7) ? (j % 300 > 200) : 1'b0;
      bit en = ($urandom_range(0, 19) != 0);
      step(cs, cr, pk, en);
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule